// File: doc/BRIEF.md
# I2C-over-AUX EDID Reply Engine

This block answers I2C-over-AUX requests aimed at a display's EDID target, standing in for a real AUX link. Software sees one control register and five data words in a small register window. It places a request header in the first data word, then writes the control register with its busy flag set. In the same clock edge the block decodes the header and updates its I2C selection state. It then overwrites the control register with a completion word and writes a reply word, carrying an ACK and, for a read, one EDID byte, back into the first data word.

EDID contents sit outside the block. The engine presents a byte index, and the owner of the EDID image returns that byte on the same cycle. Address-only messages (length 3) carry the start, restart and stop handling, steered by the middle-of-transaction flag. Single-byte reads (length 4) step through the EDID image. The index stops at the end of the image.

Top module: `aux_edid_responder`

## Requirements
- R1: After reset every register reads 0, no target is selected, EDID is marked unavailable, the sel_port output is 0 and the read index is 0.
- R2: A write to offset low byte 0x14, 0x18, 0x1C, 0x20 or 0x24 (data words 1 to 5) stores the value, and it reads back at the same offset. Writes to other offsets, apart from 0x10, change nothing, and reads from those offsets return 0.
- R3: A write to the control register (offset low byte 0x10) with bit 31 (busy) clear changes no register and no selection state.
- R4: A control write with bit 31 set replaces the control register with bit 30 (done) set and a size field in bits 24:20. The size is 2 when bit 28 of data word 1 (the read flag, bit 0 of the request code in bits 31:28) is 1, and 1 otherwise. All other control bits become 0.
- R5: On a busy write whose length field (bits 24:20 of the written value) is 3, a clear data-word-1 bit 30 (middle-of-transaction) is a stop. A stop clears the target selection and EDID availability and sets the read index to 0.
- R6: At length 3 with middle-of-transaction set, the target address in data-word-1 bits 23:8 decides the action. Address 0 resets the state as in R5. The EDID address (default 0x0050) selects the target, latches port_idx into sel_port, and sets EDID available when dp_monitor is 1. Any other address changes nothing.
- R7: A busy write with length 4 and the read flag set, while the target is selected and EDID is available, puts the EDID byte at the current index into data-word-1 bits 23:16 and advances the index by one.
- R8: When the read index has reached EDID_BYTES (default 128), a read per R7 returns byte 0 and the index does not move.
- R9: The reply written to data word 1 is {ACK code 0x00 in bits 31:24, byte in 23:16, zero in 15:0}. It is written at length 3, for write requests of any length, and for reads of length 4. Its byte is 0 except in the R7 case.
- R10: A read request with a length other than 3 or 4 updates control per R4 but leaves data word 1 and the selection state unchanged.
- R11: A length-4 read with no target selected or EDID unavailable replies with byte 0 and leaves the index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write offset; the low byte selects the register |
| wr_data | input | 32 | Write value |
| rd_addr | input | ADDR_W | Read offset |
| rd_data | output | 32 | Register value at rd_addr (combinational) |
| port_idx | input | PORT_W | Port on which this AUX channel sits |
| dp_monitor | input | 1 | A DisplayPort monitor is attached to that port |
| edid_byte | input | 8 | EDID byte at edid_index, returned combinationally |
| edid_index | output | PTR_W | Current EDID read index |
| target_sel | output | 1 | EDID target is selected |
| edid_avail | output | 1 | EDID is marked available |
| sel_port | output | PORT_W | Port latched at selection |

## Verification
The assertions assume that edid_byte settles within the same cycle as edid_index. They also assume that data word 1 is not written in the same cycle as a busy control write, which holds because there is only one write strobe. The stimulus keeps every write on that single strobe and drives it away from the clock edge. Random header words draw target addresses mostly from 0 and the EDID address, and draw lengths mostly from 3 and 4, so that selection, reading and the end-of-image stop are all reached often.

// File: rtl/aux_edid_pkg.sv
package aux_edid_pkg;
   localparam logic [7:0] OFS_CTL     = 8'h10;
   localparam int         OFS_STRIDE  = 4;
   localparam int         CTL_BUSY    = 31;
   localparam int         CTL_DONE    = 30;
   localparam int         SIZE_LSB    = 20;
   localparam int         SIZE_W      = 5;
   localparam int         HDR_READ    = 28;
   localparam int         HDR_MOT     = 30;
   localparam int         HDR_ADR_LSB = 8;
   localparam int         BYTE_LSB    = 16;

   typedef struct packed {
      logic        is_read;
      logic        mot;
      logic [15:0] taddr;
   } aux_hdr_t;
endpackage

// File: rtl/aux_reg_decode.sv
module aux_reg_decode #(
   parameter int ADDR_W   = 12,
   parameter int NUM_DATA = 5
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic                ctl_hit,
   output logic [NUM_DATA:1]   data_hit
);
   import aux_edid_pkg::*;

   logic [7:0] low;
   assign low     = addr[7:0];
   assign ctl_hit = (low == OFS_CTL);

   for (genvar k = 1; k <= NUM_DATA; k++) begin : g_hit
      localparam logic [7:0] OFS_K = 8'(int'(OFS_CTL) + OFS_STRIDE * k);
      assign data_hit[k] = (low == OFS_K);
   end
endmodule

// File: rtl/aux_hdr_decode.sv
module aux_hdr_decode (
   input  logic [31:0]               hdr_word,
   output aux_edid_pkg::aux_hdr_t    hdr
);
   import aux_edid_pkg::*;

   assign hdr.is_read = hdr_word[HDR_READ];
   assign hdr.mot     = hdr_word[HDR_MOT];
   assign hdr.taddr   = hdr_word[HDR_ADR_LSB +: 16];
endmodule

// File: rtl/aux_sel_state.sv
module aux_sel_state #(
   parameter int EDID_BYTES = 128,
   parameter int PORT_W     = 3,
   parameter int PTR_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_clear,
   input  logic              ev_select,
   input  logic              ev_read,
   input  logic [PORT_W-1:0] port_idx,
   input  logic              dp_monitor,
   output logic              target_sel,
   output logic              edid_avail,
   output logic [PORT_W-1:0] sel_port,
   output logic [PTR_W-1:0]  ptr,
   output logic              fetch_ok
);
   localparam logic [PTR_W-1:0] PTR_END = PTR_W'(EDID_BYTES);

   assign fetch_ok = target_sel && edid_avail && (ptr < PTR_END);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         target_sel <= 1'b0;
         edid_avail <= 1'b0;
         sel_port   <= '0;
         ptr        <= '0;
      end else if (ev_clear) begin
         target_sel <= 1'b0;
         edid_avail <= 1'b0;
         ptr        <= '0;
      end else if (ev_select) begin
         target_sel <= 1'b1;
         sel_port   <= port_idx;
         if (dp_monitor) edid_avail <= 1'b1;
      end else if (ev_read && fetch_ok) begin
         ptr <= ptr + 1'b1;
      end
   end

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr != $past(ptr)) |-> (ptr == $past(ptr) + 1'b1 || ptr == '0)); // R7
   AST_PTR_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= PTR_END); // R8
   AST_NOSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_read && !(target_sel && edid_avail) && !ev_clear) |=> $stable(ptr)); // R11
   AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      ev_clear |=> (!target_sel && !edid_avail && ptr == '0)); // R5
endmodule

// File: rtl/aux_edid_responder.sv
module aux_edid_responder #(
   parameter int          ADDR_W      = 12,
   parameter int          NUM_DATA    = 5,
   parameter int          EDID_BYTES  = 128,
   parameter int          PORT_W      = 3,
   parameter logic [15:0] EDID_TARGET = 16'h0050,
   parameter logic [7:0]  ACK_CODE    = 8'h00,
   parameter int          PTR_W       = $clog2(EDID_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [31:0]       rd_data,
   input  logic [PORT_W-1:0] port_idx,
   input  logic              dp_monitor,
   input  logic [7:0]        edid_byte,
   output logic [PTR_W-1:0]  edid_index,
   output logic              target_sel,
   output logic              edid_avail,
   output logic [PORT_W-1:0] sel_port
);
   import aux_edid_pkg::*;

   localparam logic [SIZE_W-1:0] LEN_ADDR_ONLY = SIZE_W'(3);
   localparam logic [SIZE_W-1:0] LEN_ONE_BYTE  = SIZE_W'(4);

   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must cover the low offset byte");
   end
   if (NUM_DATA < 1 || NUM_DATA > 59) begin : g_bad_data
      $error("NUM_DATA out of range");
   end
   if (EDID_BYTES < 1) begin : g_bad_edid
      $error("EDID_BYTES must be positive");
   end
   if (PTR_W < $clog2(EDID_BYTES + 1)) begin : g_bad_ptr
      $error("PTR_W too narrow for EDID_BYTES");
   end

   logic                  wctl_hit, rctl_hit;
   logic [NUM_DATA:1]     wdat_hit, rdat_hit;
   logic [31:0]           ctl_q;
   logic [NUM_DATA:1][31:0] data_q;
   aux_hdr_t              hdr;
   logic [SIZE_W-1:0]     req_len;
   logic                  busy_wr, len_ao, len_one;
   logic                  ev_clear, ev_select, ev_read, reply_wr, fetch_ok;
   logic [31:0]           ctl_next, reply;
   logic [7:0]            reply_byte;

   aux_reg_decode #(.ADDR_W(ADDR_W), .NUM_DATA(NUM_DATA)) u_wdec (
      .addr(wr_addr), .ctl_hit(wctl_hit), .data_hit(wdat_hit));
   aux_reg_decode #(.ADDR_W(ADDR_W), .NUM_DATA(NUM_DATA)) u_rdec (
      .addr(rd_addr), .ctl_hit(rctl_hit), .data_hit(rdat_hit));

   aux_hdr_decode u_hdr (.hdr_word(data_q[1]), .hdr(hdr));

   assign req_len  = wr_data[SIZE_LSB +: SIZE_W];
   assign busy_wr  = wr_en && wctl_hit && wr_data[CTL_BUSY];
   assign len_ao   = (req_len == LEN_ADDR_ONLY);
   assign len_one  = (req_len == LEN_ONE_BYTE);

   assign ev_clear  = busy_wr && len_ao && (!hdr.mot || hdr.taddr == 16'h0);
   assign ev_select = busy_wr && len_ao && hdr.mot && (hdr.taddr == EDID_TARGET);
   assign ev_read   = busy_wr && !len_ao && hdr.is_read && len_one;
   assign reply_wr  = busy_wr && (len_ao || !hdr.is_read || len_one);

   aux_sel_state #(.EDID_BYTES(EDID_BYTES), .PORT_W(PORT_W), .PTR_W(PTR_W)) u_state (
      .clk(clk), .rst_n(rst_n),
      .ev_clear(ev_clear), .ev_select(ev_select), .ev_read(ev_read),
      .port_idx(port_idx), .dp_monitor(dp_monitor),
      .target_sel(target_sel), .edid_avail(edid_avail), .sel_port(sel_port),
      .ptr(edid_index), .fetch_ok(fetch_ok));

   always_comb begin
      ctl_next                          = '0;
      ctl_next[CTL_DONE]                = 1'b1;
      ctl_next[SIZE_LSB +: SIZE_W]      = hdr.is_read ? SIZE_W'(2) : SIZE_W'(1);
      reply_byte                        = (ev_read && fetch_ok) ? edid_byte : 8'h00;
      reply                             = '0;
      reply[31:24]                      = ACK_CODE;
      reply[BYTE_LSB +: 8]              = reply_byte;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         data_q <= '0;
      end else begin
         if (busy_wr) ctl_q <= ctl_next;
         for (int k = 1; k <= NUM_DATA; k++) begin
            if (k == 1 && reply_wr)            data_q[k] <= reply;
            else if (wr_en && wdat_hit[k])     data_q[k] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (rctl_hit) rd_data = ctl_q;
      for (int k = 1; k <= NUM_DATA; k++) begin
         if (rdat_hit[k]) rd_data = data_q[k];
      end
   end

   AST_CTL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      busy_wr |=> (ctl_q[CTL_DONE] && !ctl_q[CTL_BUSY] &&
                   ctl_q[SIZE_LSB +: SIZE_W] == ($past(hdr.is_read) ? SIZE_W'(2) : SIZE_W'(1)))); // R4
   AST_CTL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wctl_hit && !wr_data[CTL_BUSY]) |=> $stable(ctl_q)); // R3
   AST_REPLY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      reply_wr |=> (data_q[1][31:24] == ACK_CODE && data_q[1][15:0] == 16'h0)); // R9
   AST_BADLEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_wr && hdr.is_read && !len_ao && !len_one) |=> $stable(data_q[1])); // R10
   AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wctl_hit, wdat_hit})); // R2
endmodule

// File: tb/aux_edid_responder_test.sv
module aux_edid_responder_test;
   localparam int EB = 128;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [11:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [11:0] rd_addr = '0;
   logic [31:0] rd_data;
   logic [2:0]  port_idx = '0;
   logic        dp_monitor = 1'b0;
   logic [7:0]  edid_byte;
   logic [7:0]  edid_index;
   logic        target_sel, edid_avail;
   logic [2:0]  sel_port;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [31:0] m_reg [0:5];
   logic        m_sel, m_avail;
   logic [2:0]  m_port;
   int          m_ptr;

   always #4 clk = ~clk;

   function automatic logic [7:0] edid_fn(int i);
      return 8'((i * 37 + 11) ^ (i >> 2));
   endfunction

   assign edid_byte = edid_fn(int'(edid_index));

   aux_edid_responder uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .port_idx(port_idx), .dp_monitor(dp_monitor),
      .edid_byte(edid_byte), .edid_index(edid_index), .target_sel(target_sel),
      .edid_avail(edid_avail), .sel_port(sel_port));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic int map_idx(logic [11:0] a);
      for (int k = 0; k < 6; k++) if (a[7:0] == 8'(16 + 4 * k)) return k;
      return -1;
   endfunction

   task automatic model_reset_sel();
      m_sel = 0; m_avail = 0; m_ptr = 0;
   endtask

   task automatic model_write(logic [11:0] a, logic [31:0] d);
      int idx = map_idx(a);
      logic [4:0] len;
      logic rdf, mot;
      logic [15:0] ta;
      logic [7:0] b;
      if (idx > 0) m_reg[idx] = d;
      else if (idx == 0 && d[31]) begin
         len = d[24:20]; rdf = m_reg[1][28]; mot = m_reg[1][30]; ta = m_reg[1][23:8];
         m_reg[0] = (32'h1 << 30) | (32'(rdf ? 2 : 1) << 20);
         if (len == 3) begin
            if (!mot || ta == 16'h0) model_reset_sel();
            else if (ta == 16'h0050) begin
               m_sel = 1; m_port = port_idx; if (dp_monitor) m_avail = 1;
            end
            m_reg[1] = 32'h0;
         end else if (!rdf) m_reg[1] = 32'h0;
         else if (len == 4) begin
            b = 8'h00;
            if (m_sel && m_avail && m_ptr < EB) begin b = edid_fn(m_ptr); m_ptr++; end
            m_reg[1] = {8'h00, b, 16'h0};
         end
      end
   endtask

   task automatic do_write(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      model_write(a, d);
   endtask

   task automatic check_all(string tag);
      for (int k = 0; k < 6; k++) begin
         rd_addr = 12'(16 + 4 * k); #1;
         chk(k == 0 ? "R4 ctl" : (k == 1 ? "R9 reply" : "R2 data"), rd_data, m_reg[k]);
      end
      chk({tag, " R6 target_sel"}, 32'(target_sel), 32'(m_sel));
      chk({tag, " R6 edid_avail"}, 32'(edid_avail), 32'(m_avail));
      chk({tag, " R7 index"}, 32'(edid_index), 32'(m_ptr));
      if (m_sel) chk({tag, " R6 sel_port"}, 32'(sel_port), 32'(m_port));
   endtask

   function automatic logic [31:0] hdr(bit rd, bit mot, logic [15:0] ta);
      return {1'b0, mot, 1'b0, rd, 4'h0, ta, 8'h00};
   endfunction
   function automatic logic [31:0] ctlw(bit busy, logic [4:0] len);
      return {busy, 6'h0, len, 20'h0};
   endfunction

   initial begin
      for (int k = 0; k < 6; k++) m_reg[k] = '0;
      model_reset_sel(); m_port = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 reset");
      chk("R1 sel_port", 32'(sel_port), 32'h0);

      // R2 data store and unmapped offsets
      for (int k = 1; k <= 5; k++) do_write(12'(16 + 4 * k), 32'hA5000000 + 32'(k));
      do_write(12'h028, 32'hDEADBEEF);
      do_write(12'h00C, 32'h12345678);
      rd_addr = 12'h028; #1; chk("R2 unmapped read", rd_data, 32'h0);
      check_all("R2");

      // R3 idle control write
      do_write(12'h010, ctlw(0, 5'd3));
      check_all("R3");
      chk("R3 ctl stays 0", m_reg[0], 32'h0);

      // R11 read before selection
      do_write(12'h014, hdr(1, 0, 16'h0050));
      do_write(12'h010, ctlw(1, 5'd4));
      check_all("R11");

      // R6 select without monitor, then with
      port_idx = 3'd5; dp_monitor = 1'b0;
      do_write(12'h014, hdr(0, 1, 16'h0050));
      do_write(12'h010, ctlw(1, 5'd3));
      check_all("R6 nomon");
      do_write(12'h014, hdr(1, 0, 16'h0));
      do_write(12'h010, ctlw(1, 5'd4));
      check_all("R11 unavail");
      dp_monitor = 1'b1;
      do_write(12'h014, hdr(0, 1, 16'h0050));
      do_write(12'h010, ctlw(1, 5'd3));
      check_all("R6 mon");

      // R7/R8 read to past the end
      for (int i = 0; i < EB + 3; i++) begin
         do_write(12'h014, hdr(1, 0, 16'h0));
         do_write(12'h010, ctlw(1, 5'd4));
         check_all(i < EB ? "R7" : "R8");
      end

      // R10 bad read length
      do_write(12'h014, hdr(1, 0, 16'h0));
      do_write(12'h010, ctlw(1, 5'd7));
      check_all("R10");

      // R5 stop
      do_write(12'h014, hdr(1, 0, 16'h0050));
      do_write(12'h010, ctlw(1, 5'd3));
      check_all("R5 stop");

      // random mix
      for (int i = 0; i < 3000; i++) begin
         int sel = int'($urandom_range(0, 9));
         logic [15:0] ta;
         logic [4:0] len;
         int r = int'($urandom_range(0, 3));
         ta = (r == 0) ? 16'h0 : (r == 3 ? 16'($urandom) : 16'h0050);
         r = int'($urandom_range(0, 4));
         len = (r < 2) ? 5'd3 : (r < 4 ? 5'd4 : 5'($urandom));
         port_idx = 3'($urandom); dp_monitor = 1'($urandom);
         if (sel < 4) do_write(12'h014, {1'b0, 1'($urandom), 1'b0, 1'($urandom), 4'($urandom), ta, 8'($urandom)});
         else if (sel < 8) do_write(12'h010, {1'(sel != 4), 6'($urandom), len, 20'($urandom)});
         else do_write(12'($urandom), $urandom);
         check_all("R9 random");
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      $urandom(32'd20240611);
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule